// File: doc/BRIEF.md
# Bayer Grid Exposure and White-Balance Statistics

This block sits on a stream of Bayer quads, each made of four 13-bit normalized samples (Gr, R, B, Gb). Alongside each quad it receives the four raw sensor samples the quad came from. It divides the frame into a grid of square cells and, for every cell, builds six accumulated values:
- a luminance sum,
- a count of pixels that pass a saturation gate,
- one plain sum for each of the four Bayer colours.

The gate affects only the pixel count. The four colour sums take every pixel.

Partial results for one row of cells are held in a line buffer indexed by cell column. When the final quad line of a cell row ends, the whole row of results moves into an output bank. From there it streams out, eight 32-bit words per cell in raster order, over a valid/ready port. The next cell row accumulates while the bank drains.

Configuration is a set of shadow registers. They hold their reset values until a one-cycle write strobe loads every field from the configuration inputs together.

Top module: `bayer_grid_stats`

## Requirements
- R1: A cell is N×N quads with N = 8 << cell_log2 (code 0→8, 1→16, 2→32, 3→64). Only the first grid_w cell columns and grid_h cell rows are accumulated. Quads to the right of or below them have no effect on any output word, and a frame yields exactly grid_w·grid_h·8 words.
- R2: Word 0 of a cell is the sum over its quads of floor((R·cr + G·cg + B·cb) / 65536). Here G = floor((Gr+Gb)/2), and cr, cg, cb are unsigned 16-bit fractions.
- R3: A pixel passes the gate when three conditions all hold: its raw sample (16 bits) ≤ raw_high, its processed value scaled to 16 bits ({pix,3'b000}) ≥ low, and that scaled value ≤ high. With raw_high=65535, low=0, high=65535 every pixel passes.
- R4: Word 1 of a cell counts the passing pixels, from 0 to 4 per quad. It never exceeds 4·N².
- R5: Words 2, 3, 4 and 5 of a cell are the sums of Gr, R, B and Gb respectively, over all pixels of the cell, whatever the gate decides.
- R6: Each cell emits words in the order Y sum, count, Gr, R, B, Gb, then two words that are always zero. Cells come out left to right, then top to bottom.
- R7: After reset the shadow configuration holds:
  - luminance weights cr=25559, cg=32768, cb=7209;
  - gate thresholds raw_high=65472, low=64, high=65535;
  - grid 4×2 cells, cell_log2=0.

  A cycle with cfg_we high loads all fields, and grid_w is clamped to MAX_COLS.
- R8: out_valid rises in the cycle after the clock edge that accepts the end-of-line quad of the last quad line of a cell row that lies inside the grid, and at no other time.
- R9: While out_valid is high and out_ready is low, out_data and out_valid hold. No word is lost or repeated.
- R10: A quad with in_sof set is quad (0,0) of a new frame, and any partial accumulations from an earlier frame are discarded.
- R11: During and right after reset out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load all configuration inputs into the shadow registers |
| cfg_coef_r | input | 16 | Luminance weight for R, u0.16 |
| cfg_coef_g | input | 16 | Luminance weight for averaged G, u0.16 |
| cfg_coef_b | input | 16 | Luminance weight for B, u0.16 |
| cfg_raw_high | input | 16 | Gate upper limit on raw sample |
| cfg_low | input | 16 | Gate lower limit on scaled processed value |
| cfg_high | input | 16 | Gate upper limit on scaled processed value |
| cfg_cell_log2 | input | 2 | Cell size code, N = 8 << code |
| cfg_grid_w | input | GRID_W_W (4) | Grid width in cells |
| cfg_grid_h | input | GRID_H_W (6) | Grid height in cells |
| in_valid | input | 1 | Quad present this cycle |
| in_sof | input | 1 | Quad is the first of a frame |
| in_eol | input | 1 | Quad is the last of its line |
| in_gr | input | 13 | Processed Gr sample |
| in_r | input | 13 | Processed R sample |
| in_b | input | 13 | Processed B sample |
| in_gb | input | 13 | Processed Gb sample |
| in_raw_gr | input | 16 | Raw sensor Gr sample |
| in_raw_r | input | 16 | Raw sensor R sample |
| in_raw_b | input | 16 | Raw sensor B sample |
| in_raw_gb | input | 16 | Raw sensor Gb sample |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Result word |

## Verification
The first result word of a cell row is due one cycle after the rising edge that takes the closing end-of-line quad of that row. The bench therefore checks that out_valid is still low at the falling edge where it drives that quad, and high at the next falling edge.

Result words are captured one nanosecond after each falling edge on which valid and ready are both high. All of a frame's words are collected before they are compared with a model. The model recomputes luminance, gate and sums from the requirement formulas, so the comparison does not depend on how the drain is paced. This also holds under a ready pattern that is low two cycles in three.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  localparam int PIX_W  = 13;
  localparam int RAW_W  = 16;
  localparam int COEF_W = 16;
  localparam int ACC_W  = 32;
  localparam int WORDS  = 8;

  localparam logic [COEF_W-1:0] RST_COEF_R   = 16'd25559;
  localparam logic [COEF_W-1:0] RST_COEF_G   = 16'd32768;
  localparam logic [COEF_W-1:0] RST_COEF_B   = 16'd7209;
  localparam logic [RAW_W-1:0]  RST_RAW_HIGH = 16'd65472;
  localparam logic [RAW_W-1:0]  RST_LOW      = 16'd64;
  localparam logic [RAW_W-1:0]  RST_HIGH     = 16'd65535;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [RAW_W-1:0]  raw_t;
  typedef logic [COEF_W-1:0] coef_t;
  typedef logic [ACC_W-1:0]  acc_t;

  typedef struct packed {
    acc_t y;
    acc_t cnt;
    acc_t gr;
    acc_t r;
    acc_t b;
    acc_t gb;
  } cell_acc_t;

  // Weighted luminance of one quad; G is the mean of the two greens.
  function automatic acc_t quad_luma(input pix_t gr, input pix_t r, input pix_t b,
                                     input pix_t gb, input coef_t cr, input coef_t cg,
                                     input coef_t cb);
    logic [PIX_W:0]   gsum;
    logic [ACC_W+1:0] s;
    gsum = {1'b0, gr} + {1'b0, gb};
    s = (ACC_W+2)'(r) * (ACC_W+2)'(cr)
      + (ACC_W+2)'(gsum[PIX_W:1]) * (ACC_W+2)'(cg)
      + (ACC_W+2)'(b) * (ACC_W+2)'(cb);
    return acc_t'(s >> COEF_W);
  endfunction

  // Saturation gate for one pixel.
  function automatic logic level_ok(input raw_t raw, input pix_t pix, input raw_t raw_hi,
                                    input raw_t lo, input raw_t hi);
    raw_t scaled;
    scaled = {pix, {(RAW_W-PIX_W){1'b0}}};
    return (raw <= raw_hi) && (scaled >= lo) && (scaled <= hi);
  endfunction

  function automatic cell_acc_t acc_add(input cell_acc_t a, input cell_acc_t d);
    cell_acc_t s;
    s.y   = a.y   + d.y;
    s.cnt = a.cnt + d.cnt;
    s.gr  = a.gr  + d.gr;
    s.r   = a.r   + d.r;
    s.b   = a.b   + d.b;
    s.gb  = a.gb  + d.gb;
    return s;
  endfunction
endpackage

// File: rtl/bgs_quad_calc.sv
module bgs_quad_calc
  import bgs_pkg::*;
(
  input  pix_t [3:0]  pix,      // 0:Gr 1:R 2:B 3:Gb
  input  raw_t [3:0]  raw,
  input  coef_t       coef_r,
  input  coef_t       coef_g,
  input  coef_t       coef_b,
  input  raw_t        raw_high,
  input  raw_t        low,
  input  raw_t        high,
  output cell_acc_t   contrib
);
  logic [3:0] pass;
  logic [2:0] pass_cnt;

  for (genvar g = 0; g < 4; g++) begin : g_gate
    assign pass[g] = level_ok(raw[g], pix[g], raw_high, low, high);
  end

  always_comb begin
    pass_cnt = '0;
    for (int i = 0; i < 4; i++) pass_cnt = pass_cnt + 3'(pass[i]);
  end

  always_comb begin
    contrib.y   = quad_luma(pix[0], pix[1], pix[2], pix[3], coef_r, coef_g, coef_b);
    contrib.cnt = acc_t'(pass_cnt);
    contrib.gr  = acc_t'(pix[0]);
    contrib.r   = acc_t'(pix[1]);
    contrib.b   = acc_t'(pix[2]);
    contrib.gb  = acc_t'(pix[3]);
  end
endmodule

// File: rtl/bgs_position.sv
module bgs_position #(
  parameter int POS_W    = 12,
  parameter int GRID_W_W = 4,
  parameter int GRID_H_W = 6,
  parameter int CIDX_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sof,
  input  logic                in_eol,
  input  logic [1:0]          cell_log2,
  input  logic [GRID_W_W-1:0] grid_w,
  input  logic [GRID_H_W-1:0] grid_h,
  output logic [CIDX_W-1:0]   col_sel,
  output logic                in_grid,
  output logic                row_done,
  output logic                frame_start
);
  logic [POS_W-1:0] qx, qy, cur_x, cur_y, col_idx, cell_row, sub_row, last_sub;
  logic [2:0]       shift;

  always_comb begin
    cur_x    = in_sof ? '0 : qx;
    cur_y    = in_sof ? '0 : qy;
    shift    = 3'd3 + {1'b0, cell_log2};
    col_idx  = cur_x >> shift;
    cell_row = cur_y >> shift;
    last_sub = (POS_W'(8) << cell_log2) - POS_W'(1);
    sub_row  = cur_y & last_sub;
  end

  assign col_sel     = col_idx[CIDX_W-1:0];
  assign in_grid     = in_valid && (col_idx < POS_W'(grid_w)) && (cell_row < POS_W'(grid_h));
  assign row_done    = in_valid && in_eol && (sub_row == last_sub) && (cell_row < POS_W'(grid_h));
  assign frame_start = in_valid && in_sof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qx <= '0;
      qy <= '0;
    end else if (in_valid) begin
      if (in_eol) begin
        qx <= '0;
        qy <= cur_y + POS_W'(1);
      end else begin
        qx <= cur_x + POS_W'(1);
        qy <= cur_y;
      end
    end
  end
endmodule

// File: rtl/bgs_drain.sv
module bgs_drain
  import bgs_pkg::*;
#(
  parameter int MAX_COLS = 8,
  parameter int GRID_W_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  cell_acc_t [MAX_COLS-1:0]  bank_in,
  input  logic [GRID_W_W-1:0]       ncols,
  input  logic                      out_ready,
  output logic                      out_valid,
  output acc_t                      out_data
);
  localparam int CIDX_W = $clog2(MAX_COLS);

  cell_acc_t [MAX_COLS-1:0] bank;
  cell_acc_t                sel;
  logic [GRID_W_W-1:0]      col, ncols_q;
  logic [2:0]               word;
  logic                     pend;

  assign out_valid = pend;

  always_comb begin
    sel = bank[col[CIDX_W-1:0]];
    unique case (word)
      3'd0:    out_data = sel.y;
      3'd1:    out_data = sel.cnt;
      3'd2:    out_data = sel.gr;
      3'd3:    out_data = sel.r;
      3'd4:    out_data = sel.b;
      3'd5:    out_data = sel.gb;
      default: out_data = '0;      // focus words are not computed here
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank    <= '0;
      pend    <= 1'b0;
      col     <= '0;
      word    <= '0;
      ncols_q <= '0;
    end else if (load) begin
      bank    <= bank_in;
      pend    <= (ncols != '0);
      col     <= '0;
      word    <= '0;
      ncols_q <= ncols;
    end else if (pend && out_ready) begin
      if (word == 3'(WORDS-1)) begin
        word <= '0;
        if (col == ncols_q - GRID_W_W'(1)) pend <= 1'b0;
        else                               col  <= col + GRID_W_W'(1);
      end else begin
        word <= word + 3'd1;
      end
    end
  end
endmodule

// File: rtl/bayer_grid_stats.sv
module bayer_grid_stats
  import bgs_pkg::*;
#(
  parameter int MAX_COLS     = 8,
  parameter int GRID_H_W     = 6,
  parameter int POS_W        = 12,
  parameter int DEF_GRID_W   = 4,
  parameter int DEF_GRID_H   = 2,
  parameter int DEF_LOG2     = 0,
  localparam int GRID_W_W    = $clog2(MAX_COLS + 1),
  localparam int CIDX_W      = $clog2(MAX_COLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [15:0]         cfg_coef_r,
  input  logic [15:0]         cfg_coef_g,
  input  logic [15:0]         cfg_coef_b,
  input  logic [15:0]         cfg_raw_high,
  input  logic [15:0]         cfg_low,
  input  logic [15:0]         cfg_high,
  input  logic [1:0]          cfg_cell_log2,
  input  logic [GRID_W_W-1:0] cfg_grid_w,
  input  logic [GRID_H_W-1:0] cfg_grid_h,
  input  logic                in_valid,
  input  logic                in_sof,
  input  logic                in_eol,
  input  logic [12:0]         in_gr,
  input  logic [12:0]         in_r,
  input  logic [12:0]         in_b,
  input  logic [12:0]         in_gb,
  input  logic [15:0]         in_raw_gr,
  input  logic [15:0]         in_raw_r,
  input  logic [15:0]         in_raw_b,
  input  logic [15:0]         in_raw_gb,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [31:0]         out_data
);
  // Shadow configuration
  coef_t               cfg_cr_q, cfg_cg_q, cfg_cb_q;
  raw_t                cfg_rh_q, cfg_lo_q, cfg_hi_q;
  logic [1:0]          cfg_log2_q;
  logic [GRID_W_W-1:0] cfg_gw_q;
  logic [GRID_H_W-1:0] cfg_gh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_cr_q   <= RST_COEF_R;
      cfg_cg_q   <= RST_COEF_G;
      cfg_cb_q   <= RST_COEF_B;
      cfg_rh_q   <= RST_RAW_HIGH;
      cfg_lo_q   <= RST_LOW;
      cfg_hi_q   <= RST_HIGH;
      cfg_log2_q <= 2'(DEF_LOG2);
      cfg_gw_q   <= GRID_W_W'(DEF_GRID_W);
      cfg_gh_q   <= GRID_H_W'(DEF_GRID_H);
    end else if (cfg_we) begin
      cfg_cr_q   <= cfg_coef_r;
      cfg_cg_q   <= cfg_coef_g;
      cfg_cb_q   <= cfg_coef_b;
      cfg_rh_q   <= cfg_raw_high;
      cfg_lo_q   <= cfg_low;
      cfg_hi_q   <= cfg_high;
      cfg_log2_q <= cfg_cell_log2;
      cfg_gw_q   <= (cfg_grid_w > GRID_W_W'(MAX_COLS)) ? GRID_W_W'(MAX_COLS) : cfg_grid_w;
      cfg_gh_q   <= cfg_grid_h;
    end
  end

  // Quad position and cell decode
  logic [CIDX_W-1:0] col_sel;
  logic              in_grid, row_done, frame_start;

  bgs_position #(
    .POS_W(POS_W), .GRID_W_W(GRID_W_W), .GRID_H_W(GRID_H_W), .CIDX_W(CIDX_W)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .cell_log2(cfg_log2_q), .grid_w(cfg_gw_q), .grid_h(cfg_gh_q),
    .col_sel(col_sel), .in_grid(in_grid), .row_done(row_done), .frame_start(frame_start)
  );

  // Per-quad contribution
  cell_acc_t contrib;

  bgs_quad_calc u_calc (
    .pix({in_gb, in_b, in_r, in_gr}),
    .raw({in_raw_gb, in_raw_b, in_raw_r, in_raw_gr}),
    .coef_r(cfg_cr_q), .coef_g(cfg_cg_q), .coef_b(cfg_cb_q),
    .raw_high(cfg_rh_q), .low(cfg_lo_q), .high(cfg_hi_q),
    .contrib(contrib)
  );

  // Line buffer of cell accumulators, one entry per cell column
  cell_acc_t [MAX_COLS-1:0] acc, nxt;

  always_comb begin
    nxt = frame_start ? '0 : acc;
    if (in_grid) nxt[col_sel] = acc_add(nxt[col_sel], contrib);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        acc <= '0;
    else if (row_done) acc <= '0;
    else               acc <= nxt;
  end

  // Completed cell row moves to the output bank and drains
  bgs_drain #(.MAX_COLS(MAX_COLS), .GRID_W_W(GRID_W_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .load(row_done), .bank_in(nxt), .ncols(cfg_gw_q),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        row_done,
  input logic [1:0]  cell_log2
);
  // Own count of word position, from handshakes only
  logic [2:0] wcnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                      wcnt <= '0;
    else if (out_valid && out_ready) wcnt <= wcnt + 3'd1;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> out_valid);

  p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(row_done));

  p_focus_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (wcnt >= 3'd6) |-> out_data == 32'd0);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (wcnt == 3'd1) |-> out_data <= (32'd256 << {cell_log2, 1'b0}));
endmodule

bind bayer_grid_stats bgs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .row_done(row_done), .cell_log2(cfg_log2_q)
);

// File: tb/tb_bayer_grid_stats.sv
`timescale 1ns/1ps
module tb_bayer_grid_stats;
  logic        clk = 0, rst_n = 0, cfg_we = 0;
  logic [15:0] cfg_coef_r = 0, cfg_coef_g = 0, cfg_coef_b = 0;
  logic [15:0] cfg_raw_high = 0, cfg_low = 0, cfg_high = 0;
  logic [1:0]  cfg_cell_log2 = 0;
  logic [3:0]  cfg_grid_w = 0;
  logic [5:0]  cfg_grid_h = 0;
  logic        in_valid = 0, in_sof = 0, in_eol = 0;
  logic [12:0] in_gr = 0, in_r = 0, in_b = 0, in_gb = 0;
  logic [15:0] in_raw_gr = 0, in_raw_r = 0, in_raw_b = 0, in_raw_gb = 0;
  logic        out_valid, out_ready;
  logic [31:0] out_data;

  bayer_grid_stats dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int stall_mode = 0, tick = 0;
  logic [31:0] got [0:2047];
  int got_n = 0;
  longint expv [0:63][0:5];
  int m_cr, m_cg, m_cb, m_rh, m_lo, m_hi, m_n, m_gw, m_gh;

  always @(negedge clk) begin
    tick <= tick + 1;
    out_ready <= (stall_mode == 0) ? 1'b1 : ((tick % 3) == 0);
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready && got_n < 2048) begin
      got[got_n] = out_data;
      got_n = got_n + 1;
    end
  end

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gp(int x, int y, int ch, int seed);
    return (x * 37 + y * 101 + ch * 1531 + seed * 97 + (x * y) % 53) % 8192;
  endfunction
  function automatic int graw(int x, int y, int ch, int seed);
    return (x * 733 + y * 2711 + ch * 9973 + seed * 17) % 65536;
  endfunction

  task automatic model_defaults();
    m_cr = 25559; m_cg = 32768; m_cb = 7209;
    m_rh = 65472; m_lo = 64; m_hi = 65535;
    m_n = 8; m_gw = 4; m_gh = 2;
  endtask

  task automatic set_cfg(int cr, int cg, int cb, int rh, int lo, int hi, int lg, int gw, int gh);
    @(negedge clk);
    cfg_coef_r = 16'(cr); cfg_coef_g = 16'(cg); cfg_coef_b = 16'(cb);
    cfg_raw_high = 16'(rh); cfg_low = 16'(lo); cfg_high = 16'(hi);
    cfg_cell_log2 = 2'(lg); cfg_grid_w = 4'(gw); cfg_grid_h = 6'(gh);
    cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    m_cr = cr; m_cg = cg; m_cb = cb; m_rh = rh; m_lo = lo; m_hi = hi;
    m_n = 8 << lg; m_gw = gw; m_gh = gh;
  endtask

  // Drives one frame, updates the model, checks the row-start cycle (R8).
  task automatic drive_frame(int wq, int hq, int seed, bit use_model);
    bit lat = 0;
    for (int c = 0; c < 64; c++) for (int k = 0; k < 6; k++) expv[c][k] = 0;
    for (int y = 0; y < hq; y++) begin
      for (int x = 0; x < wq; x++) begin
        int p[4], rw[4];
        @(negedge clk);
        if (lat) begin chk(out_valid === 1'b1, "R8 valid one cycle after row end", out_valid, 1); lat = 0; end
        for (int ch = 0; ch < 4; ch++) begin p[ch] = gp(x, y, ch, seed); rw[ch] = graw(x, y, ch, seed); end
        in_valid = 1; in_sof = (x == 0 && y == 0); in_eol = (x == wq - 1);
        in_gr = 13'(p[0]); in_r = 13'(p[1]); in_b = 13'(p[2]); in_gb = 13'(p[3]);
        in_raw_gr = 16'(rw[0]); in_raw_r = 16'(rw[1]); in_raw_b = 16'(rw[2]); in_raw_gb = 16'(rw[3]);
        if (use_model && x / m_n < m_gw && y / m_n < m_gh) begin
          int c = (y / m_n) * m_gw + x / m_n;
          longint yl = (longint'(p[1]) * m_cr + longint'((p[0] + p[3]) / 2) * m_cg
                        + longint'(p[2]) * m_cb) / 65536;
          expv[c][0] += yl;
          for (int ch = 0; ch < 4; ch++)
            if (rw[ch] <= m_rh && p[ch] * 8 >= m_lo && p[ch] * 8 <= m_hi) expv[c][1] += 1;
          expv[c][2] += p[0]; expv[c][3] += p[1]; expv[c][4] += p[2]; expv[c][5] += p[3];
        end
        if (use_model && x == wq - 1 && (y % m_n) == m_n - 1 && y / m_n < m_gh) begin
          chk(out_valid === 1'b0, "R8 valid low while closing quad driven", out_valid, 0);
          lat = 1;
        end
      end
      @(negedge clk);
      if (lat) begin chk(out_valid === 1'b1, "R8 valid one cycle after row end", out_valid, 1); lat = 0; end
      in_valid = 0; in_sof = 0; in_eol = 0;
    end
  endtask

  task automatic run_and_compare(int wq, int hq, int seed, string tag);
    int base = got_n;
    int total;
    drive_frame(wq, hq, seed, 1);
    total = m_gw * m_gh * 8;
    for (int w = 0; w < 20000 && (got_n - base) < total; w++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(got_n - base == total, {tag, " R1 word count"}, got_n - base, total);
    for (int c = 0; c < m_gw * m_gh; c++) begin
      chk(got[base + c*8 + 0] == 32'(expv[c][0]), {tag, " R2 Y sum"}, got[base + c*8 + 0], expv[c][0]);
      chk(got[base + c*8 + 1] == 32'(expv[c][1]), {tag, " R4 gated count"}, got[base + c*8 + 1], expv[c][1]);
      for (int k = 2; k < 6; k++)
        chk(got[base + c*8 + k] == 32'(expv[c][k]), {tag, " R5 colour sum"}, got[base + c*8 + k], expv[c][k]);
      for (int k = 6; k < 8; k++)
        chk(got[base + c*8 + k] == 32'd0, {tag, " R6 focus word zero"}, got[base + c*8 + k], 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11 out_valid low in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 out_valid low after reset", out_valid, 0);
  endtask

  task automatic t_defaults();
    model_defaults();
    run_and_compare(32, 16, 1, "R7 defaults");
  endtask

  task automatic t_config();
    set_cfg(20000, 30000, 15000, 40000, 8000, 50000, 1, 2, 2);
    run_and_compare(32, 32, 2, "R3 tight gate N=16");
  endtask

  task automatic t_gate_off();
    int base = got_n;
    set_cfg(25559, 32768, 7209, 65535, 0, 65535, 3, 1, 1);
    run_and_compare(64, 64, 3, "R3 gate off N=64");
    chk(got[base + 1] == 32'd16384, "R3 all pixels pass", got[base + 1], 16384);
  endtask

  task automatic t_outside();
    set_cfg(30000, 20000, 10000, 60000, 100, 60000, 2, 1, 1);
    run_and_compare(37, 35, 4, "R1 outside quads N=32");
  endtask

  task automatic t_restart();
    set_cfg(25559, 32768, 7209, 65472, 64, 65535, 0, 3, 1);
    drive_frame(24, 3, 9, 0);
    run_and_compare(24, 8, 5, "R10 sof restart");
  endtask

  task automatic t_backpressure();
    set_cfg(12000, 40000, 9000, 65000, 500, 64000, 0, 8, 2);
    stall_mode = 1;
    run_and_compare(64, 16, 6, "R9 stalled drain");
    stall_mode = 0;
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_config();
    t_gate_off();
    t_outside();
    t_restart();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule